// File: doc/BRIEF.md
# Dual-List Scatter-Gather Memory Copier

This block copies bytes from memory to memory. Two small internal tables describe the transfer. One table lists the source chunks and the other lists the destination chunks. Each table entry holds a start address and a byte length, and each table has its own entry count. After a start pulse, the engine reads the source chunks in table order and writes the bytes, in the same order, into the destination chunks. It moves from one entry to the next on each side independently, so the two lists may differ in entry count and in chunk sizes, and their chunk boundaries need not line up.

Reads and writes go out on a byte-wide memory port in bursts. Each burst is at most the configured burst length and never runs past the end of a chunk. A buffer one burst deep sits between the read side and the write side. A burst is read into the buffer and then written out, and it is split wherever a destination chunk ends. The copy length is the smaller of the two list totals. A residue output reports the bytes still to be written, updated once per completed burst. A one-cycle done pulse marks the end of the copy.

The memory port is assumed to accept one access every cycle. Read data returns on the cycle after the read is issued. Tables and counts are written while the engine is idle.

Top module: `sg_copy_engine`

## Requirements
- R1: The number of bytes read and written equals the smaller of the summed source lengths and the summed destination lengths. Destination bytes past that count are left untouched.
- R2: The lists may differ in entry count and chunk size. The k-th byte written, counted across all destination chunks in table order, equals the k-th byte read, counted across all source chunks in table order.
- R3: A single source entry and a single destination entry of equal length produce a plain contiguous copy.
- R4: Within a chunk, each access in a burst uses the previous access address plus one.
- R5: No run of consecutive reads is longer than `cfg_burst`, and a `cfg_burst` value of 0 acts as 1. Read runs never cross the end of a source chunk, and write runs never cross the end of a destination chunk.
- R6: An entry of length zero, on either list, is skipped and no access is made to its address.
- R7: On the cycle after start, `residue` shows the copy length. While busy it never rises. It drops only when a burst's last write has gone out, and it reads 0 when done pulses.
- R8: `done` is high for exactly one cycle, on the cycle after the last write. `busy` is high from the cycle after start until that done cycle.
- R9: A read and a write never happen in the same cycle. No access occurs while the engine is idle.
- R10: A start pulse while the engine is busy is ignored. The running copy is unchanged and finishes with a single done pulse.
- R11: When either list total is zero (for example, an entry count of 0), the engine makes no access and pulses done with residue 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_side | input | 1 | Table select: 0 source, 1 destination |
| tbl_idx | input | $clog2(NENT) | Entry index to write |
| tbl_addr | input | AW | Chunk start address |
| tbl_len | input | LW | Chunk length in bytes |
| src_count | input | $clog2(NENT+1) | Number of valid source entries |
| dst_count | input | $clog2(NENT+1) | Number of valid destination entries |
| cfg_burst | input | $clog2(MAXB+1) | Maximum burst length in bytes |
| start | input | 1 | Start pulse, taken only when idle |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| residue | output | LW+$clog2(NENT)+1 | Bytes not yet written |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
The checker enforces the following on every cycle:
- Accesses never overlap, and none occurs while idle.
- Addresses increase by one within runs, and read runs stay within the burst limit.
- Residue never rises, and done is a single-cycle pulse with residue at zero.

Only the bench scenarios can show the results of a whole copy. These are: the byte order across mismatched chunk boundaries, the minimum-total copy length, untouched bytes past the copy, skipped zero-length entries, and a second start ignored mid-copy.

// File: rtl/sg_copy_pkg.sv
// Package: shared state encoding of the scatter-gather copier.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sg_copy_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // waiting for start
        ST_S_NEXT,   // load source entry at current index
        ST_RD_SETUP, // size next read burst or skip empty chunk
        ST_RD,       // issue reads of one burst
        ST_RD_WAIT,  // last read data lands in buffer
        ST_WR_SETUP, // skip empty destination chunk or begin writes
        ST_D_NEXT,   // load destination entry at current index
        ST_WR,       // drain buffer to destination
        ST_FIN       // one-cycle completion
    } sg_state_e;

endpackage

// File: rtl/sg_list_table.sv
// Module: one chunk list (address, length) with a write port, an indexed
// combinational read port and the summed length of the first count entries.
// Assumes writes happen only while the engine is idle.
module sg_list_table #(
    parameter int NENT = 4,
    parameter int AW   = 16,
    parameter int LW   = 8,
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int CW  = $clog2(NENT + 1),
    localparam int TW  = LW + IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [AW-1:0] waddr,
    input  logic [LW-1:0] wlen,
    input  logic [CW-1:0] count,
    input  logic [IW-1:0] ridx,
    output logic [AW-1:0] raddr,
    output logic [LW-1:0] rlen,
    output logic [TW-1:0] total
);
    logic [AW-1:0] ent_addr [NENT];
    logic [LW-1:0] ent_len  [NENT];

    // Store an entry on a write strobe; clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ent_addr[i] <= '0;
                ent_len[i]  <= '0;
            end
        end else if (we) begin
            ent_addr[widx] <= waddr;
            ent_len[widx]  <= wlen;
        end
    end

    // Present the entry selected by the controller.
    always_comb begin
        raddr = ent_addr[ridx];
        rlen  = ent_len[ridx];
    end

    // Sum the lengths of the valid entries.
    always_comb begin
        total = '0;
        for (int i = 0; i < NENT; i++) begin
            if (CW'(i) < count) total = total + TW'(ent_len[i]);
        end
    end

endmodule

// File: rtl/sg_burst_buf.sv
// Module: byte buffer one burst deep; registered write, combinational read.
// Assumes the controller never reads a slot in the cycle it is written.
module sg_burst_buf #(
    parameter int MAXB = 8,
    parameter int DW   = 8,
    localparam int BIW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic           clk,
    input  logic           we,
    input  logic [BIW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [BIW-1:0] raddr,
    output logic [DW-1:0]  rdata
);
    logic [DW-1:0] slot [MAXB];

    // Capture one returning read byte.
    always_ff @(posedge clk) begin
        if (we) slot[waddr] <= wdata;
    end

    // Present the byte for the current write.
    assign rdata = slot[raddr];

endmodule

// File: rtl/sg_copy_ctrl.sv
// Module: copy sequencer. Walks both lists on their own indices, sizes read
// bursts by burst limit, source chunk remainder and bytes left, fills the
// buffer, then drains it into destination chunks, splitting at their ends.
// Assumes one access per cycle accepted and read data one cycle later.
module sg_copy_ctrl
    import sg_copy_pkg::*;
#(
    parameter int NENT = 4,
    parameter int AW   = 16,
    parameter int LW   = 8,
    parameter int MAXB = 8,
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int TW  = LW + IW + 1,
    localparam int BW  = $clog2(MAXB + 1),
    localparam int BIW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [BW-1:0]  cfg_burst,
    input  logic [TW-1:0]  src_total,
    input  logic [TW-1:0]  dst_total,
    output logic [IW-1:0]  src_idx,
    input  logic [AW-1:0]  src_ent_addr,
    input  logic [LW-1:0]  src_ent_len,
    output logic [IW-1:0]  dst_idx,
    input  logic [AW-1:0]  dst_ent_addr,
    input  logic [LW-1:0]  dst_ent_len,
    output logic           buf_we,
    output logic [BIW-1:0] buf_waddr,
    output logic [BIW-1:0] buf_raddr,
    output logic           busy,
    output logic           done,
    output logic [TW-1:0]  residue,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr
);
    sg_state_e     st;
    logic [AW-1:0] saddr, daddr;
    logic [LW-1:0] srem, drem;
    logic [TW-1:0] rd_left;
    logic [BW-1:0] blen, rcnt, bfill, bidx;
    logic [BW-1:0] cfg_eff;
    logic [BW-1:0] blen_n;
    logic [TW-1:0] copy_len;
    logic          rd_pend;
    logic [BIW-1:0] rd_slot;

    // Effective burst limit: zero behaves as one.
    assign cfg_eff = (cfg_burst == '0) ? BW'(1) : cfg_burst;

    // Copy length is the smaller list total.
    assign copy_len = (src_total < dst_total) ? src_total : dst_total;

    // Next read burst: min of limit, chunk remainder and bytes left.
    always_comb begin
        logic [TW-1:0] m;
        m = TW'(cfg_eff);
        if (TW'(srem) < m) m = TW'(srem);
        if (rd_left < m)   m = rd_left;
        blen_n = BW'(m);
    end

    // Sequence the copy through its states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            src_idx <= '0;
            dst_idx <= '0;
            saddr   <= '0;
            daddr   <= '0;
            srem    <= '0;
            drem    <= '0;
            rd_left <= '0;
            residue <= '0;
            blen    <= '0;
            rcnt    <= '0;
            bfill   <= '0;
            bidx    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    // Index starts at all ones so the first advance wraps to 0.
                    src_idx <= '1;
                    dst_idx <= '1;
                    srem    <= '0;
                    drem    <= '0;
                    rd_left <= copy_len;
                    residue <= copy_len;
                    st      <= (copy_len == '0) ? ST_FIN : ST_RD_SETUP;
                end
                ST_RD_SETUP: begin
                    if (srem == '0) begin
                        src_idx <= src_idx + 1'b1;
                        st      <= ST_S_NEXT;
                    end else begin
                        blen <= blen_n;
                        rcnt <= '0;
                        st   <= ST_RD;
                    end
                end
                ST_S_NEXT: begin
                    saddr <= src_ent_addr;
                    srem  <= src_ent_len;
                    st    <= ST_RD_SETUP;
                end
                ST_RD: begin
                    saddr   <= saddr + 1'b1;
                    srem    <= srem - 1'b1;
                    rd_left <= rd_left - 1'b1;
                    rcnt    <= rcnt + 1'b1;
                    if (rcnt + 1'b1 == blen) st <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    bfill <= blen;
                    bidx  <= '0;
                    st    <= ST_WR_SETUP;
                end
                ST_WR_SETUP: begin
                    if (drem == '0) begin
                        dst_idx <= dst_idx + 1'b1;
                        st      <= ST_D_NEXT;
                    end else begin
                        st <= ST_WR;
                    end
                end
                ST_D_NEXT: begin
                    daddr <= dst_ent_addr;
                    drem  <= dst_ent_len;
                    st    <= ST_WR_SETUP;
                end
                ST_WR: begin
                    daddr <= daddr + 1'b1;
                    drem  <= drem - 1'b1;
                    bidx  <= bidx + 1'b1;
                    if (bidx + 1'b1 == bfill) begin
                        residue <= rd_left;
                        st      <= (rd_left == '0) ? ST_FIN : ST_RD_SETUP;
                    end else if (drem == LW'(1)) begin
                        st <= ST_WR_SETUP;
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Register the slot of each issued read for capture one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_slot <= '0;
        end else begin
            rd_pend <= (st == ST_RD);
            rd_slot <= BIW'(rcnt);
        end
    end

    // Drive memory strobes, address, buffer ports and status.
    always_comb begin
        mem_rd    = (st == ST_RD);
        mem_wr    = (st == ST_WR);
        mem_addr  = (st == ST_WR) ? daddr : saddr;
        buf_we    = rd_pend;
        buf_waddr = rd_slot;
        buf_raddr = BIW'(bidx);
        busy      = (st != ST_IDLE);
        done      = (st == ST_FIN);
    end

endmodule

// File: rtl/sg_copy_engine.sv
// Module: top of the dual-list scatter-gather memory copier. Holds the two
// chunk tables and the burst buffer, and the sequencer that drives them.
// Assumes tables and counts are written only while busy is low.
module sg_copy_engine #(
    parameter int NENT = 4,
    parameter int AW   = 16,
    parameter int LW   = 8,
    parameter int MAXB = 8,
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int CW  = $clog2(NENT + 1),
    localparam int TW  = LW + IW + 1,
    localparam int BW  = $clog2(MAXB + 1),
    localparam int BIW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic          tbl_side,
    input  logic [IW-1:0] tbl_idx,
    input  logic [AW-1:0] tbl_addr,
    input  logic [LW-1:0] tbl_len,
    input  logic [CW-1:0] src_count,
    input  logic [CW-1:0] dst_count,
    input  logic [BW-1:0] cfg_burst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [TW-1:0] residue,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    logic [IW-1:0]  src_idx, dst_idx;
    logic [AW-1:0]  src_ent_addr, dst_ent_addr;
    logic [LW-1:0]  src_ent_len, dst_ent_len;
    logic [TW-1:0]  src_total, dst_total;
    logic           buf_we;
    logic [BIW-1:0] buf_waddr, buf_raddr;

    sg_list_table #(.NENT(NENT), .AW(AW), .LW(LW)) u_src_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we && !tbl_side), .widx(tbl_idx), .waddr(tbl_addr), .wlen(tbl_len),
        .count(src_count), .ridx(src_idx),
        .raddr(src_ent_addr), .rlen(src_ent_len), .total(src_total)
    );

    sg_list_table #(.NENT(NENT), .AW(AW), .LW(LW)) u_dst_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we && tbl_side), .widx(tbl_idx), .waddr(tbl_addr), .wlen(tbl_len),
        .count(dst_count), .ridx(dst_idx),
        .raddr(dst_ent_addr), .rlen(dst_ent_len), .total(dst_total)
    );

    sg_burst_buf #(.MAXB(MAXB), .DW(8)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(mem_rdata),
        .raddr(buf_raddr), .rdata(mem_wdata)
    );

    sg_copy_ctrl #(.NENT(NENT), .AW(AW), .LW(LW), .MAXB(MAXB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_burst(cfg_burst),
        .src_total(src_total), .dst_total(dst_total),
        .src_idx(src_idx), .src_ent_addr(src_ent_addr), .src_ent_len(src_ent_len),
        .dst_idx(dst_idx), .dst_ent_addr(dst_ent_addr), .dst_ent_len(dst_ent_len),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_raddr(buf_raddr),
        .busy(busy), .done(done), .residue(residue),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr)
    );

endmodule

// File: rtl/sg_copy_chk.sv
// Module: protocol checker for sg_copy_engine, attached by bind.
// Assumes cfg_burst is held steady while the engine is busy.
module sg_copy_chk #(
    parameter int AW = 16,
    parameter int TW = 11,
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [BW-1:0] cfg_burst,
    input logic          busy,
    input logic          done,
    input logic [TW-1:0] residue
);
    logic [7:0] rd_run;

    // Count reads that came before this one in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_run <= '0;
        else if (mem_rd) rd_run <= (rd_run == 8'hFF) ? rd_run : rd_run + 1'b1;
        else             rd_run <= '0;
    end

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R4
    rd_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R4
    wr_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R5
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ({1'b0, rd_run} < ((cfg_burst == '0) ? 9'd1 : 9'(cfg_burst))));

    // R7
    residue_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (residue <= $past(residue)));

    // R7
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (residue == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind sg_copy_engine sg_copy_chk #(.AW(AW), .TW(TW), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .cfg_burst(cfg_burst), .busy(busy),
    .done(done), .residue(residue)
);

// File: tb/sg_copy_engine_bench.sv
// Directed bench for sg_copy_engine with a 256-byte memory model.
module sg_copy_engine_bench;
    localparam int NENT = 4;
    localparam int AW   = 8;
    localparam int LW   = 8;
    localparam int MAXB = 8;
    localparam int IW   = 2;
    localparam int CW   = 3;
    localparam int TW   = LW + IW + 1;
    localparam int BW   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tbl_we, tbl_side, start;
    logic [IW-1:0] tbl_idx;
    logic [AW-1:0] tbl_addr;
    logic [LW-1:0] tbl_len;
    logic [CW-1:0] src_count, dst_count;
    logic [BW-1:0] cfg_burst;
    logic          busy, done, mem_rd, mem_wr;
    logic [TW-1:0] residue;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sg_copy_engine #(.NENT(NENT), .AW(AW), .LW(LW), .MAXB(MAXB)) u_sg_copy_engine (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_side(tbl_side),
        .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_len(tbl_len),
        .src_count(src_count), .dst_count(dst_count), .cfg_burst(cfg_burst),
        .start(start), .busy(busy), .done(done), .residue(residue),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one access per cycle, read data one cycle later.
    logic [7:0] mem [256];
    logic [7:0] init_img [256];
    logic [7:0] exp_img [256];
    logic [7:0] rdq;
    always @(posedge clk) begin
        if (mem_rd) rdq <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end
    assign mem_rdata = rdq;

    // Monitor of accesses.
    logic       mon_clr = 1'b0;
    int         n_rd, n_wr, run, max_run, n_done, rise;
    logic [TW-1:0] prev_res;
    logic [255:0] touched;
    always @(posedge clk) begin
        if (mon_clr) begin
            n_rd = 0; n_wr = 0; run = 0; max_run = 0; n_done = 0; rise = 0;
            touched = '0; prev_res = '1;
        end else begin
            if (mem_rd) begin
                n_rd++; run++;
                if (run > max_run) max_run = run;
                touched[mem_addr] = 1'b1;
            end else run = 0;
            if (mem_wr) begin n_wr++; touched[mem_addr] = 1'b1; end
            if (done) n_done++;
            if (busy && residue > prev_res) rise++;
            prev_res = busy ? residue : '1;
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Bench copies of the lists for the expected model.
    logic [AW-1:0] b_sa [NENT], b_da [NENT];
    int            b_sl [NENT], b_dl [NENT];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prog(input bit side, input int idx, input int addr, input int len);
        @(negedge clk);
        tbl_we = 1'b1; tbl_side = side; tbl_idx = IW'(idx);
        tbl_addr = AW'(addr); tbl_len = LW'(len);
        if (side) begin b_da[idx] = AW'(addr); b_dl[idx] = len; end
        else      begin b_sa[idx] = AW'(addr); b_sl[idx] = len; end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Run one copy and check it against the flattened-list model.
    task automatic run_copy(input string tag, input int sc, input int dc,
                            input int burst, input int exp_max_run, input bit restart);
        int stot, dtot, n, k, bad, wait_c;
        logic [AW-1:0] sflat [1024];
        logic [AW-1:0] dflat [1024];
        stot = 0; dtot = 0;
        for (int i = 0; i < sc; i++)
            for (int j = 0; j < b_sl[i]; j++) begin sflat[stot] = b_sa[i] + AW'(j); stot++; end
        for (int i = 0; i < dc; i++)
            for (int j = 0; j < b_dl[i]; j++) begin dflat[dtot] = b_da[i] + AW'(j); dtot++; end
        n = (stot < dtot) ? stot : dtot;
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            init_img[a] = 8'(a * 7 + 3) ^ 8'h5A;
            mem[a] = init_img[a];
            exp_img[a] = init_img[a];
        end
        for (k = 0; k < n; k++) exp_img[dflat[k]] = init_img[sflat[k]];
        src_count = CW'(sc); dst_count = CW'(dc); cfg_burst = BW'(burst);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: residue shows the copy length one cycle after start
        check(residue == TW'(n), {tag, " R7 residue at start"}, int'(residue), n);
        // R8: busy from the cycle after start
        check(busy == 1'b1, {tag, " R8 busy after start"}, int'(busy), 1);
        if (restart) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_c = 0;
        while (n_done == 0 && wait_c < 3000) begin @(negedge clk); wait_c++; end
        repeat (12) @(negedge clk);
        bad = 0;
        for (int a = 0; a < 256; a++) if (mem[a] !== exp_img[a]) bad++;
        // R1 R2: data image matches, bytes past copy untouched
        check(bad == 0, {tag, " R1/R2 memory image mismatches"}, bad, 0);
        // R1: access counts equal the smaller total
        check(n_rd == n, {tag, " R1 read count"}, n_rd, n);
        check(n_wr == n, {tag, " R1 write count"}, n_wr, n);
        // R5: longest read run
        check(max_run == exp_max_run, {tag, " R5 longest read run"}, max_run, exp_max_run);
        // R8 R10: exactly one done pulse, back to idle
        check(n_done == 1, {tag, " R8/R10 done pulses"}, n_done, 1);
        check(busy == 1'b0, {tag, " R8 idle after done"}, int'(busy), 0);
        // R7: residue rests at zero and never rose
        check(residue == '0 && rise == 0, {tag, " R7 residue end/rise"}, int'(residue) + rise, 0);
    endtask

    // R3: single entry each side, plain contiguous copy.
    task automatic t_single;
        prog(0, 0, 8'h10, 12);
        prog(1, 0, 8'h80, 12);
        run_copy("single", 1, 1, 4, 4, 1'b0);
        // R3: last byte of contiguous block copied
        check(mem[8'h8B] === init_img[8'h1B], "R3 last contiguous byte",
              int'(mem[8'h8B]), int'(init_img[8'h1B]));
    endtask

    // R2 R1: mismatched lists, source shorter; bytes past copy untouched.
    task automatic t_src_short;
        prog(0, 0, 8'h00, 5);
        prog(0, 1, 8'h20, 7);
        prog(0, 2, 8'h40, 4);
        prog(1, 0, 8'h90, 9);
        prog(1, 1, 8'hC0, 10);
        run_copy("srcshort", 3, 2, 4, 4, 1'b0);
        // R1: destination byte 17 of 19 left untouched
        check(mem[8'hC7] === init_img[8'hC7], "R1 byte past copy untouched",
              int'(mem[8'hC7]), int'(init_img[8'hC7]));
    endtask

    // R2 R5: destination shorter, larger burst, chunk-bound read runs.
    task automatic t_dst_short;
        prog(0, 0, 8'h00, 10);
        prog(0, 1, 8'h30, 10);
        prog(1, 0, 8'h90, 3);
        prog(1, 1, 8'hA0, 4);
        prog(1, 2, 8'hB0, 5);
        run_copy("dstshort", 2, 3, 8, 8, 1'b0);
    endtask

    // R6: zero-length entries on both lists.
    task automatic t_zero;
        prog(0, 0, 8'h70, 0);
        prog(0, 1, 8'h00, 6);
        prog(0, 2, 8'h71, 0);
        prog(0, 3, 8'h20, 5);
        prog(1, 0, 8'hF0, 0);
        prog(1, 1, 8'h90, 11);
        run_copy("zero", 4, 2, 3, 3, 1'b0);
        // R6: no access to zero-length entry addresses
        check(touched[8'h70] == 1'b0 && touched[8'h71] == 1'b0 && touched[8'hF0] == 1'b0,
              "R6 zero-length address touched", int'(touched[8'h70]) + int'(touched[8'hF0]), 0);
    endtask

    // R10 R5: second start mid-copy ignored; burst setting 0 acts as 1.
    task automatic t_restart;
        prog(0, 0, 8'h10, 9);
        prog(1, 0, 8'h80, 9);
        run_copy("restart", 1, 1, 0, 1, 1'b1);
    endtask

    // R11: empty source list gives immediate done without access.
    task automatic t_empty;
        prog(1, 0, 8'h80, 6);
        run_copy("empty", 0, 1, 4, 0, 1'b0);
        // R11: nothing touched
        check(touched == '0, "R11 no access on empty copy", int'(n_rd + n_wr), 0);
    endtask

    initial begin
        rst_n = 1'b0; tbl_we = 1'b0; tbl_side = 1'b0; start = 1'b0;
        tbl_idx = '0; tbl_addr = '0; tbl_len = '0;
        src_count = '0; dst_count = '0; cfg_burst = BW'(4);
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R8 R9 R7: reset state
        check(busy == 1'b0 && done == 1'b0, "R8 reset busy/done", int'(busy) + int'(done), 0);
        check(residue == '0, "R7 reset residue", int'(residue), 0);
        check(n_rd + n_wr == 0, "R9 no access while idle", n_rd + n_wr, 0);
        t_single;
        t_src_short;
        t_dst_short;
        t_zero;
        t_restart;
        t_empty;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule